// File: doc/BRIEF.md
# Byte-Lane DRAM Access Controller

This block converts single-word host requests into multiplexed-address cycles for a 64K x 16 dynamic RAM. The RAM has one row strobe and two column strobes, one for each byte. The host presents a 16-bit word address, 16-bit write data, a direction bit and two byte enables, and holds the request until `done` pulses. The controller starts a cycle only while an arbiter's `grant` is high. It then issues the row half of the address under a falling row strobe and the column half under the falling column strobes. Only the column strobes of enabled bytes take part.

Every timing minimum is a parameter counted in clock cycles: row-to-column delay, active row time, row and column precharge, the access times from row, column address, column strobe and output enable, column address hold and write pulse. The sequencer computes from these when read data becomes valid and when the cycle may close. All strobes return high together, and the next cycle waits out the longer of the two precharge times. The data bus is split into an output word, an enable and an input word. The bus is driven only while write enable is active.

Top module: `dram_lane_ctrl`

## Requirements
- R1: The row address pins carry `req_addr[15:8]` when `ras_n` falls. They carry `req_addr[7:0]` when the first column strobe falls.
- R2: `req_be[0]` selects `lcas_n` and data bits 7:0. `req_be[1]` selects `ucas_n` and bits 15:8. Only the strobes of enabled bytes go low, and both fall in the same cycle.
- R3: A read keeps `we_n` high and drops `oe_n` together with the column strobes. `rdata` is captured in the cycle after the data-valid point, which is max(T_RAC, T_RCD + max(T_AA, T_CAC, T_OE)) cycles after the row strobe falls. Byte lanes that are not enabled read as zero.
- R4: A write drops `we_n` in the cycle the column strobes fall, with `dq_oe` high and the write data on `dq_out`. `we_n` stays low for T_WP cycles.
- R5: `ras_n` stays low for at least T_RAS cycles. Both column strobes are high in the cycle `ras_n` rises.
- R6: `ras_n` does not fall until all strobes have been high for at least max(T_RP, T_CP) cycles. This also holds for the first cycle after reset.
- R7: The column address stays on the pins from the column strobe fall to the end of the cycle. `ras_n` stays low for at least T_AR cycles.
- R8: A request with both byte enables zero pulses `done` in the next cycle and issues no DRAM cycle.
- R9: Each accepted request produces exactly one row cycle, or none if R8 applies, and exactly one single-cycle `done` pulse.
- R10: `dq_oe` is high only while `we_n` is low.
- R11: No cycle starts while `grant` is low. `ras_n` falls only in the cycle after one where `grant` was high.
- R12: During and after reset all strobes, `we_n` and `oe_n` are high, and `dq_oe` and `done` are low.
- R13: A column strobe is low only while `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until done |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address (row = upper byte) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| grant | input | 1 | Arbiter permission to start a cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 8 | Multiplexed address pins |
| dq_out | output | 16 | Data driven toward the RAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 16 | Data returned by the RAM |

## Verification
A bench RAM model returns garbage until every access time has elapsed, so a capture that comes one cycle early shows up as wrong read data. The bench also applies full-word, lower-byte and upper-byte writes and reads to the same word. These patterns tell a swapped lane, a missing mask or a swapped row/column split apart from correct behaviour, because each one leaves a different readback. Zero-enable requests, grant held low for several cycles, and random back-to-back traffic exercise the immediate completion, start gating and precharge spacing.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_IDLE = 3'd1,
    ST_ROW  = 3'd2,
    ST_COL  = 3'd3,
    ST_ACK  = 3'd4
  } dlc_state_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycle index, counted from the row strobe fall, at which read data is valid
  function automatic int unsigned data_valid_idx(input int unsigned trac,
                                                 input int unsigned trcd,
                                                 input int unsigned taa,
                                                 input int unsigned tcac,
                                                 input int unsigned toe);
    return imax(trac, trcd + imax(taa, imax(tcac, toe)));
  endfunction

  // last cycle index with the row strobe low for a read
  function automatic int unsigned read_end_idx(input int unsigned dv,
                                               input int unsigned tras,
                                               input int unsigned tar);
    return imax(dv, imax(tras - 1, tar - 1));
  endfunction

  // last cycle index with the row strobe low for a write
  function automatic int unsigned write_end_idx(input int unsigned trcd,
                                                input int unsigned twp,
                                                input int unsigned tras,
                                                input int unsigned tar);
    return imax(trcd + twp - 1, imax(tras - 1, tar - 1));
  endfunction

  function automatic int unsigned precharge_len(input int unsigned trp,
                                                input int unsigned tcp);
    return imax(trp, tcp);
  endfunction

endpackage

// File: rtl/dlc_seq.sv
module dlc_seq
  import dlc_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_CP  = 2,
  parameter int unsigned T_RAC = 5,
  parameter int unsigned T_AA  = 2,
  parameter int unsigned T_CAC = 2,
  parameter int unsigned T_OE  = 2,
  parameter int unsigned T_AR  = 5,
  parameter int unsigned T_WP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_we,
  input  logic lanes_any,
  input  logic grant,
  output logic ev_accept,
  output logic ev_zero,
  output logic ev_capture,
  output logic ras_n,
  output logic cas_act,
  output logic we_act,
  output logic oe_act,
  output logic col_sel,
  output logic done
);

  localparam int unsigned DV      = data_valid_idx(T_RAC, T_RCD, T_AA, T_CAC, T_OE);
  localparam int unsigned RD_END  = read_end_idx(DV, T_RAS, T_AR);
  localparam int unsigned WR_END  = write_end_idx(T_RCD, T_WP, T_RAS, T_AR);
  localparam int unsigned PRE_LEN = precharge_len(T_RP, T_CP);
  localparam int unsigned CNT_MAX = imax(imax(RD_END, WR_END), PRE_LEN) + 1;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  dlc_state_e     st_q;
  logic [CW-1:0]  cnt_q;
  logic           wr_q;
  logic           idle_take;
  logic           col_start;
  logic           wp_end;
  logic           ev_release;
  logic           pre_done;

  always_comb begin
    idle_take  = (st_q == ST_IDLE) && req && grant;
    ev_accept  = idle_take && lanes_any;
    ev_zero    = idle_take && !lanes_any;
    col_start  = (st_q == ST_ROW) && (cnt_q == CW'(T_RCD - 1));
    wp_end     = (st_q == ST_COL) && wr_q && (cnt_q == CW'(T_RCD + T_WP - 1));
    ev_capture = (st_q == ST_COL) && !wr_q && (cnt_q == CW'(DV));
    ev_release = (st_q == ST_COL) &&
                 (cnt_q == (wr_q ? CW'(WR_END) : CW'(RD_END)));
    pre_done   = (st_q == ST_PRE) && (cnt_q == CW'(PRE_LEN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PRE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      ras_n   <= 1'b1;
      cas_act <= 1'b0;
      we_act  <= 1'b0;
      oe_act  <= 1'b0;
      col_sel <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= ev_zero || ev_capture || (ev_release && wr_q);
      case (st_q)
        ST_PRE: begin
          if (pre_done) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_IDLE: begin
          if (ev_zero) begin
            st_q <= ST_ACK;
          end else if (ev_accept) begin
            st_q  <= ST_ROW;
            cnt_q <= '0;
            wr_q  <= req_we;
            ras_n <= 1'b0;
          end
        end
        ST_ROW: begin
          cnt_q <= cnt_q + CW'(1);
          if (col_start) begin
            st_q    <= ST_COL;
            cas_act <= 1'b1;
            col_sel <= 1'b1;
            we_act  <= wr_q;
            oe_act  <= !wr_q;
          end
        end
        ST_COL: begin
          cnt_q <= cnt_q + CW'(1);
          if (wp_end) we_act <= 1'b0;
          if (ev_release) begin
            st_q    <= ST_PRE;
            cnt_q   <= '0;
            ras_n   <= 1'b1;
            cas_act <= 1'b0;
            we_act  <= 1'b0;
            oe_act  <= 1'b0;
            col_sel <= 1'b0;
          end
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_PRE;
      endcase
    end
  end

endmodule

// File: rtl/dlc_addr.sv
module dlc_addr #(
  parameter int unsigned HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [2*HALF_W-1:0]   word_addr,
  input  logic                  col_sel,
  output logic [HALF_W-1:0]     pin_addr
);

  localparam int unsigned AW = 2 * HALF_W;

  logic [HALF_W-1:0] row_q;
  logic [HALF_W-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load) begin
      row_q <= word_addr[AW-1:HALF_W];
      col_q <= word_addr[HALF_W-1:0];
    end
  end

  assign pin_addr = col_sel ? col_q : row_q;

endmodule

// File: rtl/dlc_lane.sv
module dlc_lane #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LANES*LANE_W-1:0]  wdata_in,
  input  logic [LANES-1:0]         be_in,
  input  logic                     capture,
  input  logic                     cas_act,
  input  logic                     we_act,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES-1:0]         cas_n,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe,
  output logic [LANES*LANE_W-1:0]  rdata
);

  localparam int unsigned DW = LANES * LANE_W;

  logic [LANES-1:0] be_q;
  logic [DW-1:0]    wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q    <= '0;
      wdata_q <= '0;
    end else if (load) begin
      be_q    <= be_in;
      wdata_q <= wdata_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n[g] = !(cas_act && be_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        rdata[g*LANE_W +: LANE_W] <= be_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

  assign dq_out = wdata_q;
  assign dq_oe  = we_act;

endmodule

// File: rtl/dram_lane_ctrl.sv
module dram_lane_ctrl
  import dlc_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_RAS  = 6,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_CP   = 2,
  parameter int unsigned T_RAC  = 5,
  parameter int unsigned T_AA   = 2,
  parameter int unsigned T_CAC  = 2,
  parameter int unsigned T_OE   = 2,
  parameter int unsigned T_AR   = 5,
  parameter int unsigned T_WP   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    req_we,
  input  logic [2*ROW_W-1:0]      req_addr,
  input  logic [2*LANE_W-1:0]     req_wdata,
  input  logic [1:0]              req_be,
  input  logic                    grant,
  output logic                    done,
  output logic [2*LANE_W-1:0]     rdata,
  output logic                    ras_n,
  output logic                    lcas_n,
  output logic                    ucas_n,
  output logic                    we_n,
  output logic                    oe_n,
  output logic [ROW_W-1:0]        dram_addr,
  output logic [2*LANE_W-1:0]     dq_out,
  output logic                    dq_oe,
  input  logic [2*LANE_W-1:0]     dq_in
);

  localparam int unsigned LANES   = 2;
  localparam int unsigned PRE_LEN = precharge_len(T_RP, T_CP);

  // named events for the bound checker
  logic ev_accept;
  logic ev_zero;
  logic ev_capture;
  logic cas_act;
  logic we_act;
  logic oe_act;
  logic col_sel;
  logic [LANES-1:0] lane_cas_n;
  logic [15:0] lim_ras;
  logic [15:0] lim_pre;

  assign lim_ras = 16'(T_RAS);
  assign lim_pre = 16'(PRE_LEN);

  dlc_seq #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RAC(T_RAC),
    .T_AA(T_AA), .T_CAC(T_CAC), .T_OE(T_OE), .T_AR(T_AR), .T_WP(T_WP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .lanes_any  (|req_be),
    .grant      (grant),
    .ev_accept  (ev_accept),
    .ev_zero    (ev_zero),
    .ev_capture (ev_capture),
    .ras_n      (ras_n),
    .cas_act    (cas_act),
    .we_act     (we_act),
    .oe_act     (oe_act),
    .col_sel    (col_sel),
    .done       (done)
  );

  dlc_addr #(.HALF_W(ROW_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .word_addr (req_addr),
    .col_sel   (col_sel),
    .pin_addr  (dram_addr)
  );

  dlc_lane #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept),
    .wdata_in (req_wdata),
    .be_in    (req_be),
    .capture  (ev_capture),
    .cas_act  (cas_act),
    .we_act   (we_act),
    .dq_in    (dq_in),
    .cas_n    (lane_cas_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rdata    (rdata)
  );

  assign lcas_n = lane_cas_n[0];
  assign ucas_n = lane_cas_n[1];
  assign we_n   = !we_act;
  assign oe_n   = !oe_act;

endmodule

// File: rtl/dlc_chk.sv
module dlc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        grant,
  input logic        ras_n,
  input logic        lcas_n,
  input logic        ucas_n,
  input logic        we_n,
  input logic        oe_n,
  input logic        dq_oe,
  input logic        done,
  input logic        ev_accept,
  input logic        ev_zero,
  input logic [15:0] lim_ras,
  input logic [15:0] lim_pre
);

  logic [15:0] low_run;
  logic [15:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= ras_n ? 16'd0 : ((low_run == 16'hFFFF) ? low_run : low_run + 16'd1);
      high_run <= (ras_n && lcas_n && ucas_n) ?
                  ((high_run == 16'hFFFF) ? high_run : high_run + 16'd1) : 16'd0;
    end
  end

  // R5
  ras_active_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run >= lim_ras));

  // R5
  strobes_rise_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lcas_n && ucas_n));

  // R6
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_run >= lim_pre));

  // R13
  cas_inside_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcas_n || !ucas_n) |-> !ras_n);

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  // R3
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  zero_lane_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> (done && ras_n));

  // R11
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(grant));

  // R11
  accept_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ras_n);

endmodule

bind dram_lane_ctrl dlc_chk u_dlc_chk (.*);

// File: tb/test_dram_lane_ctrl.sv
`timescale 1ns/1ps
module test_dram_lane_ctrl;

  localparam int P_RCD = 2;
  localparam int P_RAS = 6;
  localparam int P_RP  = 3;
  localparam int P_CP  = 2;
  localparam int P_RAC = 5;
  localparam int P_AA  = 2;
  localparam int P_CAC = 2;
  localparam int P_OE  = 2;
  localparam int P_AR  = 5;
  localparam int P_WP  = 2;
  localparam int P_PRE = (P_RP > P_CP) ? P_RP : P_CP;
  localparam int P_CA  = (P_CAC > P_AA) ? P_CAC : P_AA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        grant = 1'b1;
  logic        done;
  logic [15:0] rdata;
  logic        ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [7:0]  dram_addr;
  logic [15:0] dq_out;
  logic [15:0] mdq = 16'h5A5A;
  logic [15:0] dq_in;

  assign dq_in = mdq;
  always #2 clk = ~clk;

  dram_lane_ctrl #(
    .T_RCD(P_RCD), .T_RAS(P_RAS), .T_RP(P_RP), .T_CP(P_CP), .T_RAC(P_RAC),
    .T_AA(P_AA), .T_CAC(P_CAC), .T_OE(P_OE), .T_AR(P_AR), .T_WP(P_WP)
  ) i_dram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .grant(grant), .done(done),
    .rdata(rdata), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mem  [0:65535];
  logic [15:0] gold [0:65535];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] masked_read(input logic [15:0] w, input logic [1:0] b);
    return {b[1] ? w[15:8] : 8'h00, b[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge_write(input logic [15:0] old, input logic [15:0] d,
                                              input logic [1:0] b);
    return {b[1] ? d[15:8] : old[15:8], b[0] ? d[7:0] : old[7:0]};
  endfunction

  // ---------------- RAM model ----------------
  int r_age = 0, c_age = 0, o_age = 0, lo_len = 0, hi_len = 0, ras_falls = 0;
  logic prev_ras = 1'b1, prev_cl = 1'b0;
  logic [7:0] m_row = '0, m_col = '0;
  logic [1:0] cur_be = '0;
  logic cur_we = 1'b0;
  logic [15:0] cur_addr = '0;

  always @(negedge clk) begin
    logic cl;
    if (!rst_n) begin
      r_age = 0; c_age = 0; o_age = 0; lo_len = 0; hi_len = 0;
      prev_ras = 1'b1; prev_cl = 1'b0; mdq = 16'h5A5A;
    end else begin
      cl = !lcas_n || !ucas_n;
      if (prev_ras && !ras_n) begin
        m_row = dram_addr;
        ras_falls++;
        chk(hi_len >= P_PRE, "R6 precharge", hi_len, P_PRE);
        chk(dram_addr == cur_addr[15:8], "R1 row", dram_addr, cur_addr[15:8]);
        lo_len = 0;
      end
      if (!prev_ras && ras_n) begin
        chk(lo_len >= P_RAS, "R5 ras low", lo_len, P_RAS);
        chk(lo_len >= P_AR, "R7 ras vs tAR", lo_len, P_AR);
        chk(lcas_n && ucas_n, "R5 strobes up", {lcas_n, ucas_n}, 3);
      end
      if (cl && !prev_cl) begin
        m_col = dram_addr;
        chk(dram_addr == cur_addr[7:0], "R1 column", dram_addr, cur_addr[7:0]);
        chk({!ucas_n, !lcas_n} == cur_be, "R2 lanes", {!ucas_n, !lcas_n}, cur_be);
        chk(we_n == !cur_we, "R4 we_n at cas", we_n, !cur_we);
        chk(oe_n == cur_we, "R3 oe_n at cas", oe_n, cur_we);
      end
      if (cl && dram_addr != m_col) chk(1'b0, "R7 column hold", dram_addr, m_col);
      if (cl && ras_n) chk(1'b0, "R13 cas outside row", ras_n, 0);
      if (dq_oe && we_n) chk(1'b0, "R10 bus driven", dq_oe, 0);
      if (!we_n && cl) begin
        if (!dq_oe) chk(1'b0, "R4 write drive", dq_oe, 1);
        if (!lcas_n) mem[{m_row, m_col}][7:0]  = dq_out[7:0];
        if (!ucas_n) mem[{m_row, m_col}][15:8] = dq_out[15:8];
      end
      r_age = ras_n ? 0 : r_age + 1;
      c_age = cl ? c_age + 1 : 0;
      o_age = !oe_n ? o_age + 1 : 0;
      mdq = 16'h5A5A;
      if (!ras_n && cl && !oe_n && we_n && r_age > P_RAC && c_age > P_CA && o_age > P_OE) begin
        mdq[7:0]  = !lcas_n ? mem[{m_row, m_col}][7:0]  : 8'hC3;
        mdq[15:8] = !ucas_n ? mem[{m_row, m_col}][15:8] : 8'hC3;
      end
      if (!ras_n) lo_len++;
      if (ras_n && lcas_n && ucas_n) hi_len++; else hi_len = 0;
      prev_ras = ras_n;
      prev_cl = cl;
    end
  end

  // ---------------- host side ----------------
  task automatic do_op(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] b, input int gd);
    int n0;
    int cyc;
    if (b == 2'b00) repeat (P_PRE + 3) @(negedge clk);
    cur_be = b; cur_we = w; cur_addr = a;
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be = b;
    grant = (gd == 0);
    n0 = ras_falls;
    for (int i = 0; i < gd; i++) begin
      @(negedge clk);
      chk(ras_falls == n0, "R11 no start without grant", ras_falls, n0);
    end
    grant = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 200);
    req = 1'b0;
    chk(done, "R9 done seen", done, 1);
    if (b == 2'b00) begin
      chk(cyc == 1, "R8 immediate done", cyc, 1);
      chk(ras_falls == n0, "R8 no cycle", ras_falls, n0);
    end else begin
      chk(ras_falls == n0 + 1, "R9 one cycle", ras_falls, n0 + 1);
      if (!w) chk(rdata == masked_read(gold[a], b), "R3 read data", rdata,
                  masked_read(gold[a], b));
      else gold[a] = merge_write(gold[a], d, b);
    end
    @(negedge clk);
    chk(!done, "R9 pulse width", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9173));
    for (int i = 0; i < 65536; i++) begin
      mem[i]  = 16'(i * 37 + 11);
      gold[i] = 16'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R12 strobes in reset",
        {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'h1F);
    chk(!dq_oe && !done, "R12 bus and done in reset", {dq_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && !dq_oe && !done, "R12 after reset",
        {ras_n, lcas_n, ucas_n, dq_oe, done}, 5'h1C);

    // directed: full word, lower byte, upper byte (R1 R2 R3 R4)
    do_op(1'b1, 16'h0102, 16'hA1B2, 2'b11, 0);
    do_op(1'b0, 16'h0102, 16'h0000, 2'b11, 0);
    do_op(1'b1, 16'h0102, 16'h1234, 2'b01, 0);
    do_op(1'b0, 16'h0102, 16'h0000, 2'b11, 0);
    do_op(1'b1, 16'h0201, 16'h77EE, 2'b10, 0);
    do_op(1'b0, 16'h0201, 16'h0000, 2'b10, 0);
    do_op(1'b0, 16'h0201, 16'h0000, 2'b01, 0);
    // zero enables, then readback shows no write (R8)
    do_op(1'b1, 16'h0102, 16'hFFFF, 2'b00, 0);
    do_op(1'b0, 16'h0102, 16'h0000, 2'b00, 0);
    do_op(1'b0, 16'h0102, 16'h0000, 2'b11, 0);
    // grant held low (R11)
    do_op(1'b0, 16'h0201, 16'h0000, 2'b11, 4);
    do_op(1'b1, 16'h0300, 16'h5566, 2'b11, 3);
    // back-to-back across rows (R6)
    do_op(1'b1, 16'h00FF, 16'h0F0F, 2'b11, 0);
    do_op(1'b1, 16'hFF00, 16'hF0F0, 2'b11, 0);
    do_op(1'b0, 16'h00FF, 16'h0000, 2'b11, 0);
    do_op(1'b0, 16'hFF00, 16'h0000, 2'b11, 0);

    // constrained random traffic
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      logic [1:0] b;
      logic w;
      int gd;
      a  = {8'($urandom % 4), 8'($urandom)};
      b  = 2'($urandom);
      w  = 1'($urandom);
      gd = (($urandom % 4) == 0) ? int'($urandom % 3) : 0;
      do_op(w, a, 16'($urandom), b, gd);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule